// File: doc/BRIEF.md
# DMA Bus-Master Enable Controller

This block decides when a PCI bridge may act as bus master for a DMA transfer that the add-on side starts. Three values are loaded through a small register-load port: a direction bit, a starting DMA address and a transfer count. Once both the address and the count have been loaded and the count is not zero, the block arms the master enable for the chosen direction. Each completed transfer strobe lowers the count by one and moves the address on by one word. When the count runs out, the enable is dropped and the transfer is wound up.

The two directions finish differently. A read, which carries data from PCI into the add-on, may already have pulled in words that are not needed. It therefore passes through a one-cycle recovery state that pulses an active-low reset to the inbound FIFO and discards them. A write, which carries data toward PCI, keeps its master enable high after the count reaches zero, until the outbound FIFO reports empty. Its recovery cycle leaves the inbound FIFO alone. At the end of either direction a done flag is raised, and both the address and the count must be loaded again before another transfer can start.

The control is a three-state machine. IDLE moves to ACTIVE (transition START) when both registers are loaded and the count is not zero. ACTIVE moves to RECOVERY (transition FINISH) when the count is zero and either the direction is read or the outbound FIFO is empty. RECOVERY always returns to IDLE on the next cycle (transition WRAP). Every other case holds the current state.

Top module: `dmaen_ctrl`

## Requirements
- R1: While the synchronous active-low reset is sampled low, the block clears the count, the address, the direction and the done flag, and it forgets any earlier loads. From the next cycle on, both enables are low and the inbound FIFO reset is high (inactive).
- R2: A load is performed when `cfg_wr` is high and the state is IDLE. `cfg_sel` chooses the target: 2'b00 loads the address from `cfg_data`, 2'b01 loads the count from the low CW bits, 2'b10 loads the direction from bit 0 (1 = read into the add-on, 0 = write toward PCI). The code 2'b11 changes nothing.
- R3: Neither enable asserts unless the address and the count have both been loaded since the last reset or the last completion.
- R4: `rd_mst_en` is high exactly when the state is ACTIVE, the direction is read and the count is not zero.
- R5: `wr_mst_en` is high exactly when the state is ACTIVE, the direction is write, and the count is not zero or `ob_empty` is low.
- R6: A `xfer_stb` in ACTIVE with a non-zero count lowers the count by one and raises the address by ADDR_STEP (4) in the next cycle. A strobe at count zero, or in any state other than ACTIVE, changes neither value.
- R7: A read whose count has reached zero goes to RECOVERY on the next edge and stays there for exactly one cycle. `ib_fifo_rst_n` is low during that cycle and at no other time.
- R8: A write whose count is zero stays in ACTIVE, with `wr_mst_en` high, for as long as `ob_empty` is low. It then passes through RECOVERY with `ib_fifo_rst_n` held high.
- R9: `done` goes high on leaving RECOVERY and stays high until a count load or a reset.
- R10: Loads of any register outside IDLE are ignored, so a new count or address presented during a transfer does not change `xfer_cnt` or `dma_addr`.
- R11: Loading a count of zero with a valid address does not start a transfer: both enables stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Register-load strobe |
| cfg_sel | input | 2 | Load target select (00 address, 01 count, 10 direction) |
| cfg_data | input | AW | Load data |
| xfer_stb | input | 1 | One transfer completed |
| ob_empty | input | 1 | Outbound FIFO empty flag |
| rd_mst_en | output | 1 | Master enable for DMA reads |
| wr_mst_en | output | 1 | Master enable for DMA writes |
| ib_fifo_rst_n | output | 1 | Active-low inbound FIFO reset pulse |
| done | output | 1 | Transfer finished |
| dma_addr | output | AW | Current DMA address |
| xfer_cnt | output | CW | Remaining transfer count |

## Verification
The hardest condition to reach is the write drain. In that window the count is already zero, yet the machine must stay in ACTIVE with the write enable up, and then it must leave through a recovery cycle that does not touch the inbound FIFO. The stimulus holds `ob_empty` low for a set number of cycles after the last strobe, checking the enable and the FIFO reset in each of those cycles, and only then releases the flag. Extra strobes are also sent at count zero inside that window to show that the count saturates. Loads that arrive mid-transfer are sent while ACTIVE is held, and their lack of effect is read back on `xfer_cnt` and `dma_addr`.

// File: rtl/dmaen_pkg.sv
package dmaen_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_RECOV  = 2'd2
    } dma_st_e;

    localparam logic [1:0] SEL_ADDR = 2'b00;
    localparam logic [1:0] SEL_CNT  = 2'b01;
    localparam logic [1:0] SEL_DIR  = 2'b10;
endpackage

// File: rtl/dmaen_regs.sv
module dmaen_regs #(
    parameter int AW        = 32,
    parameter int CW        = 16,
    parameter int ADDR_STEP = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wr,
    input  logic [1:0]    cfg_sel,
    input  logic [AW-1:0] cfg_data,
    input  logic          xfer_stb,
    input  logic          st_idle,
    input  logic          st_active,
    input  logic          st_recov,
    output logic [AW-1:0] addr_q,
    output logic [CW-1:0] cnt_q,
    output logic          dir_q,
    output logic          armed,
    output logic          cnt_zero,
    output logic          done_q
);
    import dmaen_pkg::*;

    localparam logic [AW-1:0] STEP_V  = AW'(ADDR_STEP);
    localparam logic [CW-1:0] CNT_ONE = CW'(1);

    logic addr_ok_q;
    logic cnt_ok_q;
    logic ld_ok;
    logic step_ok;

    assign ld_ok    = cfg_wr & st_idle;
    assign cnt_zero = (cnt_q == '0);
    assign step_ok  = st_active & xfer_stb & ~cnt_zero;
    assign armed    = addr_ok_q & cnt_ok_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q    <= '0;
            cnt_q     <= '0;
            dir_q     <= 1'b0;
            addr_ok_q <= 1'b0;
            cnt_ok_q  <= 1'b0;
            done_q    <= 1'b0;
        end else begin
            if (st_recov) begin
                addr_ok_q <= 1'b0;
                cnt_ok_q  <= 1'b0;
                done_q    <= 1'b1;
            end
            if (ld_ok) begin
                unique case (cfg_sel)
                    SEL_ADDR: begin
                        addr_q    <= cfg_data;
                        addr_ok_q <= 1'b1;
                    end
                    SEL_CNT: begin
                        cnt_q    <= cfg_data[CW-1:0];
                        cnt_ok_q <= 1'b1;
                        done_q   <= 1'b0;
                    end
                    SEL_DIR: dir_q <= cfg_data[0];
                    default: ;
                endcase
            end
            if (step_ok) begin
                cnt_q  <= cnt_q - CNT_ONE;
                addr_q <= addr_q + STEP_V;
            end
        end
    end

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (st_active && xfer_stb && !cnt_zero) |=> (cnt_q == $past(cnt_q) - CNT_ONE)); // R6
    AST_CNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_zero && !(cfg_wr && st_idle && cfg_sel == SEL_CNT)) |=> cnt_zero); // R6
    AST_LOAD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_idle && !xfer_stb) |=> ($stable(cnt_q) && $stable(addr_q) && $stable(dir_q))); // R10
endmodule

// File: rtl/dmaen_fsm.sv
module dmaen_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic armed,
    input  logic cnt_zero,
    input  logic dir_rd,
    input  logic ob_empty,
    output dmaen_pkg::dma_st_e state_q,
    output logic st_idle,
    output logic st_active,
    output logic st_recov
);
    import dmaen_pkg::*;

    dma_st_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (armed && !cnt_zero) state_d = ST_ACTIVE;
            ST_ACTIVE: if (cnt_zero && (dir_rd || ob_empty)) state_d = ST_RECOV;
            ST_RECOV:  state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        st_idle   = (state_q == ST_IDLE);
        st_active = (state_q == ST_ACTIVE);
        st_recov  = (state_q == ST_RECOV);
    end

    AST_RECOV_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RECOV) |=> (state_q == ST_IDLE)); // R7
    AST_WR_DRAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACTIVE && !dir_rd && !ob_empty) |=> (state_q == ST_ACTIVE)); // R8
    AST_RD_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACTIVE && dir_rd && cnt_zero) |=> (state_q == ST_RECOV)); // R7
endmodule

// File: rtl/dmaen_outs.sv
module dmaen_outs (
    input  logic clk,
    input  logic rst_n,
    input  dmaen_pkg::dma_st_e state_q,
    input  logic dir_rd,
    input  logic cnt_zero,
    input  logic ob_empty,
    output logic rd_en,
    output logic wr_en,
    output logic ib_rst_n
);
    import dmaen_pkg::*;

    always_comb begin
        rd_en    = 1'b0;
        wr_en    = 1'b0;
        ib_rst_n = 1'b1;
        unique case (state_q)
            ST_IDLE: ;
            ST_ACTIVE: begin
                rd_en = dir_rd & ~cnt_zero;
                wr_en = ~dir_rd & (~cnt_zero | ~ob_empty);
            end
            ST_RECOV: ib_rst_n = ~dir_rd;
            default: ;
        endcase
    end

    AST_FIFO_RST_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        !ib_rst_n |-> (state_q == ST_RECOV && dir_rd)); // R7
    AST_WR_NO_FIFO_RST: assert property (@(posedge clk) disable iff (!rst_n)
        !dir_rd |-> ib_rst_n); // R8
endmodule

// File: rtl/dmaen_ctrl.sv
module dmaen_ctrl #(
    parameter int AW        = 32,
    parameter int CW        = 16,
    parameter int ADDR_STEP = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wr,
    input  logic [1:0]    cfg_sel,
    input  logic [AW-1:0] cfg_data,
    input  logic          xfer_stb,
    input  logic          ob_empty,
    output logic          rd_mst_en,
    output logic          wr_mst_en,
    output logic          ib_fifo_rst_n,
    output logic          done,
    output logic [AW-1:0] dma_addr,
    output logic [CW-1:0] xfer_cnt
);
    import dmaen_pkg::*;

    dma_st_e state_q;
    logic    st_idle, st_active, st_recov;
    logic    armed, cnt_zero, dir_q, done_q;
    logic [AW-1:0] addr_q;
    logic [CW-1:0] cnt_q;

    dmaen_regs #(.AW(AW), .CW(CW), .ADDR_STEP(ADDR_STEP)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_sel   (cfg_sel),
        .cfg_data  (cfg_data),
        .xfer_stb  (xfer_stb),
        .st_idle   (st_idle),
        .st_active (st_active),
        .st_recov  (st_recov),
        .addr_q    (addr_q),
        .cnt_q     (cnt_q),
        .dir_q     (dir_q),
        .armed     (armed),
        .cnt_zero  (cnt_zero),
        .done_q    (done_q)
    );

    dmaen_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .armed     (armed),
        .cnt_zero  (cnt_zero),
        .dir_rd    (dir_q),
        .ob_empty  (ob_empty),
        .state_q   (state_q),
        .st_idle   (st_idle),
        .st_active (st_active),
        .st_recov  (st_recov)
    );

    dmaen_outs u_outs (
        .clk      (clk),
        .rst_n    (rst_n),
        .state_q  (state_q),
        .dir_rd   (dir_q),
        .cnt_zero (cnt_zero),
        .ob_empty (ob_empty),
        .rd_en    (rd_mst_en),
        .wr_en    (wr_mst_en),
        .ib_rst_n (ib_fifo_rst_n)
    );

    assign done     = done_q;
    assign dma_addr = addr_q;
    assign xfer_cnt = cnt_q;

    AST_EN_NEEDS_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_mst_en || wr_mst_en) |-> armed); // R3
    AST_EN_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_mst_en && wr_mst_en)); // R4
    AST_RD_EN_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        rd_mst_en |-> (xfer_cnt != '0)); // R4
    AST_WR_EN_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mst_en |-> (!dir_q && (xfer_cnt != '0 || !ob_empty))); // R5
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (!rd_mst_en && !wr_mst_en)); // R9
endmodule

// File: tb/dmaen_ctrl_tb.sv
module dmaen_ctrl_tb;
    localparam int AW = 32;
    localparam int CW = 16;

    typedef struct packed {
        logic        dir;
        logic [7:0]  cnt;
        logic [31:0] base;
        logic [3:0]  drain;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{1'b1, 8'd3, 32'h0000_1000, 4'd0},
        '{1'b0, 8'd2, 32'h0000_2000, 4'd3},
        '{1'b1, 8'd1, 32'h0000_3FFC, 4'd0},
        '{1'b0, 8'd1, 32'h0000_4000, 4'd0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_wr = 1'b0;
    logic [1:0]    cfg_sel = 2'b00;
    logic [AW-1:0] cfg_data = '0;
    logic          xfer_stb = 1'b0;
    logic          ob_empty = 1'b1;
    logic          rd_mst_en, wr_mst_en, ib_fifo_rst_n, done;
    logic [AW-1:0] dma_addr;
    logic [CW-1:0] xfer_cnt;

    int total = 0;
    int bad   = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    dmaen_ctrl #(.AW(AW), .CW(CW), .ADDR_STEP(4)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_data(cfg_data), .xfer_stb(xfer_stb), .ob_empty(ob_empty),
        .rd_mst_en(rd_mst_en), .wr_mst_en(wr_mst_en),
        .ib_fifo_rst_n(ib_fifo_rst_n), .done(done),
        .dma_addr(dma_addr), .xfer_cnt(xfer_cnt)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic load(input logic [1:0] sel, input logic [31:0] data);
        cfg_wr = 1'b1; cfg_sel = sel; cfg_data = data;
        tick();
        cfg_wr = 1'b0;
        #1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; xfer_stb = 1'b0; cfg_wr = 1'b0; ob_empty = 1'b1;
        tick(); tick();
        rst_n = 1'b1;
        #1;
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            finish_run();
        end
    end

    initial begin
        do_reset();
        // R1: reset state
        chk("R1 cnt", xfer_cnt, 0);
        chk("R1 addr", dma_addr, 0);
        chk("R1 rd_en", rd_mst_en, 0);
        chk("R1 wr_en", wr_mst_en, 0);
        chk("R1 fifo_rst_n", ib_fifo_rst_n, 1);
        chk("R1 done", done, 0);

        // Table walk: one full transfer per vector (R4 R5 R6 R7 R8 R9)
        for (int i = 0; i < 4; i++) begin
            ob_empty = VECS[i].dir;
            load(2'b10, {31'd0, VECS[i].dir});
            load(2'b00, VECS[i].base);
            load(2'b01, {24'd0, VECS[i].cnt});
            chk("R3 idle before start", rd_mst_en | wr_mst_en, 0);
            chk("R9 done cleared by count load", done, 0);
            tick();
            chk("R4 rd_en active", rd_mst_en, VECS[i].dir);
            chk("R5 wr_en active", wr_mst_en, !VECS[i].dir);
            xfer_stb = 1'b1;
            for (int k = 0; k < 256; k++) begin
                if (k < int'(VECS[i].cnt)) tick();
            end
            xfer_stb = 1'b0;
            #1;
            chk("R6 cnt drained", xfer_cnt, 0);
            chk("R6 addr advanced", dma_addr, VECS[i].base + 4 * VECS[i].cnt);
            chk("R4 rd_en off at zero", rd_mst_en, 0);
            if (!VECS[i].dir) begin
                for (int k = 0; k < 16; k++) begin
                    if (k < int'(VECS[i].drain)) begin
                        chk("R8 wr_en held while draining", wr_mst_en, 1);
                        chk("R8 no fifo reset while draining", ib_fifo_rst_n, 1);
                        tick();
                    end
                end
                chk("R8 wr_en still high before empty", wr_mst_en, 1);
                ob_empty = 1'b1;
                #1;
                chk("R5 wr_en off once empty", wr_mst_en, 0);
            end
            chk("R7 no fifo reset before recovery", ib_fifo_rst_n, 1);
            tick();
            chk("R7 fifo reset only on read recovery", ib_fifo_rst_n, !VECS[i].dir);
            chk("R9 done not yet", done, 0);
            tick();
            chk("R7 fifo reset one cycle", ib_fifo_rst_n, 1);
            chk("R9 done after recovery", done, 1);
            chk("R4 rd_en idle", rd_mst_en | wr_mst_en, 0);
        end

        // R3 / R9: after completion only count reloaded -> no start
        load(2'b01, 32'd4);
        chk("R9 done cleared", done, 0);
        tick(); tick();
        chk("R3 no enable without address", rd_mst_en | wr_mst_en, 0);
        // R6: strobe in IDLE ignored
        xfer_stb = 1'b1; tick(); xfer_stb = 1'b0; #1;
        chk("R6 idle strobe ignored", xfer_cnt, 4);
        // R2: select 11 has no effect
        load(2'b11, 32'hDEAD_BEEF);
        chk("R2 sel11 cnt", xfer_cnt, 4);
        chk("R2 sel11 addr", dma_addr, 32'h0000_4004);
        tick();
        chk("R2 sel11 no start", rd_mst_en | wr_mst_en, 0);

        // R2 / R10: read transfer, loads during ACTIVE ignored
        load(2'b10, 32'd1);
        load(2'b00, 32'h0000_8000);
        chk("R2 addr loaded", dma_addr, 32'h0000_8000);
        tick();
        chk("R3 both loaded enables read", rd_mst_en, 1);
        load(2'b01, 32'd9);
        chk("R10 count load ignored", xfer_cnt, 4);
        load(2'b00, 32'h0000_F000);
        chk("R10 address load ignored", dma_addr, 32'h0000_8000);
        load(2'b10, 32'd0);
        chk("R10 direction load ignored", rd_mst_en, 1);

        // R1: reset mid-transfer
        do_reset();
        chk("R1 mid-transfer cnt", xfer_cnt, 0);
        chk("R1 mid-transfer en", rd_mst_en | wr_mst_en, 0);
        chk("R1 mid-transfer fifo", ib_fifo_rst_n, 1);

        // R11: zero count does not start
        load(2'b00, 32'h0000_0100);
        load(2'b01, 32'd0);
        tick(); tick();
        chk("R11 zero count no enable", rd_mst_en | wr_mst_en, 0);
        chk("R11 zero count no done", done, 0);
        chk("R11 fifo idle", ib_fifo_rst_n, 1);

        // R6 / R8: saturation during write drain
        load(2'b10, 32'd0);
        load(2'b01, 32'd1);
        ob_empty = 1'b0;
        tick();
        chk("R5 write enabled", wr_mst_en, 1);
        xfer_stb = 1'b1; tick(); tick(); tick(); xfer_stb = 1'b0; #1;
        chk("R6 saturate cnt", xfer_cnt, 0);
        chk("R6 saturate addr", dma_addr, 32'h0000_0104);
        chk("R8 drain enable", wr_mst_en, 1);
        ob_empty = 1'b1;
        tick();
        chk("R8 write recovery keeps fifo", ib_fifo_rst_n, 1);
        tick();
        chk("R9 write done", done, 1);

        finish_run();
    end
endmodule